// File: doc/BRIEF.md
# Host-Initiated SRAM Read Sequencer

This block is the device-side controller for a programmed read of an external associative-data SRAM. The host issues a read instruction over two consecutive cycles. The instruction is carried on a small command bus and on the wide bidirectional data bus. The block checks that the instruction is a read, that it selects SRAM space and that it names this device's ID. It then assembles a 22-bit SRAM address and steps through a fixed turnaround. During that turnaround the host lets go of the data bus, the device takes the data bus and the acknowledge line, pulses the SRAM chip-enable and address-latch strobes with the address, and returns the acknowledge as a LOW, HIGH, LOW handshake before releasing it.

Two configuration fields stretch the timing. The pipeline-depth field moves every SRAM-side event later. The hit-latency field moves only the acknowledge HIGH and the final acknowledge LOW. The access is blocking: a busy flag covers the whole access, and any instruction presented while it is high is ignored. The block produces only output-enable controls for the shared buses. The SRAM data path is outside it.

Top module: `sram_rd_seq`

## Requirements
- R1: A read is the pair of cycles 1A and 1B in which `cmd_valid`=1 and `cmd_op`=2'b01, with the space and ID checks met in both. If cycle 1B fails any check, the access is abandoned, busy drops and nothing is driven.
- R2: An instruction is taken only when `dq_in[20:19]`=2'b10. Any other value leaves the block idle with every enable low.
- R3: An instruction is taken only when `dq_in[25:21]` equals `dev_id`. Otherwise every enable stays low and busy stays low.
- R4: The address is captured in cycle 1A. `sadr[21:19]` comes from `cmd_hi`, `sadr[13:0]` comes from `dq_in[13:0]` and `sadr[18:14]` is zero. `sadr` reads zero whenever `sadr_oe`=0.
- R5: With both configuration fields zero, counting 1A, 1B, 2, 3, ...: in cycles 2 and 3 nothing is driven. In cycle 4 `dq_oe`=1 and `ack_oe`=1 with `ack`=0. In cycle 5 `sadr_oe`=1, `ce_n`=0, `ale_n`=0, `ack`=1 and `dq_oe`=1. In cycle 6 the strobes are high, `sadr_oe`=`dq_oe`=0 and `ack`=0 is still driven. From cycle 7 on, `ack_oe`=0.
- R6: A pipeline-depth value T (`cfg_pipe`) moves every event of R5 from cycle 4 onward T cycles later.
- R7: A hit-latency value H (`cfg_hlat`) moves the acknowledge HIGH and the final acknowledge LOW H cycles later, with `ack` held driven LOW in between. The data-bus, address and strobe timing does not change.
- R8: `busy` is high in cycle 1A (combinationally) and stays high through the last cycle in which `ack_oe`=1. Instructions presented while busy have no effect.
- R9: `cfg_pipe` and `cfg_hlat` are sampled in cycle 1B. Changes after that do not affect the running access.
- R10: A synchronous `rst` ends any access. In the following cycle every enable is low, `ce_n`=`ale_n`=1 and `busy`=0 with idle inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command bus valid |
| cmd_op | input | 2 | Instruction opcode |
| cmd_hi | input | 3 | Upper SRAM address bits carried on the command bus |
| dq_in | input | 68 | Data bus as seen by the device |
| dev_id | input | 5 | This device's ID |
| cfg_pipe | input | 2 | Pipeline-depth setting |
| cfg_hlat | input | 3 | Hit-latency setting |
| dq_oe | output | 1 | Device drives the data bus |
| sadr | output | 22 | SRAM address |
| sadr_oe | output | 1 | Device drives the SRAM address bus |
| ce_n | output | 1 | SRAM chip enable, active low |
| ale_n | output | 1 | SRAM address latch enable, active low |
| ack | output | 1 | Acknowledge value |
| ack_oe | output | 1 | Device drives the acknowledge line |
| busy | output | 1 | Access in progress; new instructions ignored |

## Verification
The assertions assume that the inputs change only away from the clock edge and carry no unknown values once reset has been applied. They also assume that a reset is held for at least one clock edge before the first instruction. The bench satisfies these assumptions by changing every input one time unit after the rising edge, driving all-zero idle values between instructions, and opening with several reset cycles. Within those limits the stimulus is deliberately hostile. It presents instructions while an access is busy, changes the configuration in mid-access and aborts on cycle 1B, so that the acknowledge-shape and blocking properties are exercised where they could break.

// File: rtl/srs_pkg.sv
package srs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_RUN     = 2'd2
    } srs_state_e;

    // First cycle of the turnaround in which the device may drive, before shifting
    localparam int unsigned DRIVE_START = 4;
    // Cycle number given to the first cycle after the two instruction cycles
    localparam int unsigned RUN_FIRST   = 2;
endpackage

// File: rtl/srs_decode.sv
module srs_decode #(
    parameter int unsigned DQ_W      = 68,
    parameter int unsigned ID_W      = 5,
    parameter int unsigned ADR_W     = 22,
    parameter int unsigned LOW_W     = 14,
    parameter int unsigned HI_W      = 3,
    parameter int unsigned OP_W      = 2,
    parameter logic [1:0]  RD_OP     = 2'b01,
    parameter int unsigned SPACE_LSB = 19,
    parameter int unsigned ID_LSB    = 21
) (
    input  logic             cmd_valid,
    input  logic [OP_W-1:0]  cmd_op,
    input  logic [HI_W-1:0]  cmd_hi,
    input  logic [DQ_W-1:0]  dq_in,
    input  logic [ID_W-1:0]  dev_id,
    output logic             rd_hit,
    output logic [ADR_W-1:0] addr
);
    localparam logic [1:0] SRAM_SPACE = 2'b10;

    logic op_ok, space_ok, id_ok;

    always_comb begin
        op_ok    = cmd_valid && (cmd_op == OP_W'(RD_OP));
        space_ok = (dq_in[SPACE_LSB +: 2] == SRAM_SPACE);
        id_ok    = (dq_in[ID_LSB +: ID_W] == dev_id);
        rd_hit   = op_ok && space_ok && id_ok;
    end

    always_comb begin
        addr = '0;
        addr[LOW_W-1:0]        = dq_in[LOW_W-1:0];
        addr[ADR_W-1 -: HI_W]  = cmd_hi;
    end
endmodule

// File: rtl/srs_seq.sv
module srs_seq
    import srs_pkg::*;
#(
    parameter int unsigned ADR_W  = 22,
    parameter int unsigned TLSZ_W = 2,
    parameter int unsigned HLAT_W = 3,
    parameter int unsigned CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_hit,
    input  logic [ADR_W-1:0]  addr_in,
    input  logic [TLSZ_W-1:0] cfg_pipe,
    input  logic [HLAT_W-1:0] cfg_hlat,
    output srs_state_e        st,
    output logic [CNT_W-1:0]  cnt,
    output logic [ADR_W-1:0]  addr,
    output logic [TLSZ_W-1:0] tl,
    output logic [HLAT_W-1:0] hl
);
    typedef struct packed {
        srs_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADR_W-1:0]  addr;
        logic [TLSZ_W-1:0] tl;
        logic [HLAT_W-1:0] hl;
    } seq_s;

    seq_s s_d, s_q;
    logic [CNT_W-1:0] last_q;

    always_comb begin
        last_q = CNT_W'(DRIVE_START + 2) + CNT_W'(s_q.tl) + CNT_W'(s_q.hl);
        s_d    = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (rd_hit) begin
                    s_d.st   = ST_CONFIRM;
                    s_d.addr = addr_in;
                end
            end
            ST_CONFIRM: begin
                if (rd_hit) begin
                    s_d.st  = ST_RUN;
                    s_d.cnt = CNT_W'(RUN_FIRST);
                    s_d.tl  = cfg_pipe;
                    s_d.hl  = cfg_hlat;
                end else begin
                    s_d.st  = ST_IDLE;
                end
            end
            ST_RUN: begin
                if (s_q.cnt == last_q) begin
                    s_d.st  = ST_IDLE;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{st: ST_IDLE, cnt: '0, addr: '0, tl: '0, hl: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign st   = s_q.st;
    assign cnt  = s_q.cnt;
    assign addr = s_q.addr;
    assign tl   = s_q.tl;
    assign hl   = s_q.hl;

    // R9: configuration is frozen while the access runs
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (s_q.st == ST_RUN && s_d.st == ST_RUN) |=> ($stable(s_q.tl) && $stable(s_q.hl)));
    // R1: a confirm cycle always ends within one clock
    a_r1_confirm_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (s_q.st == ST_CONFIRM) |=> (s_q.st != ST_CONFIRM));
endmodule

// File: rtl/srs_drive.sv
module srs_drive
    import srs_pkg::*;
#(
    parameter int unsigned ADR_W  = 22,
    parameter int unsigned TLSZ_W = 2,
    parameter int unsigned HLAT_W = 3,
    parameter int unsigned CNT_W  = 5
) (
    input  logic              running,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [ADR_W-1:0]  addr,
    input  logic [TLSZ_W-1:0] tl,
    input  logic [HLAT_W-1:0] hl,
    output logic              dq_oe,
    output logic [ADR_W-1:0]  sadr,
    output logic              sadr_oe,
    output logic              ce_n,
    output logic              ale_n,
    output logic              ack,
    output logic              ack_oe
);
    logic [CNT_W-1:0] c_drive, c_strobe, c_ack_hi, c_ack_end;
    logic             at_strobe;

    always_comb begin
        c_drive   = CNT_W'(DRIVE_START) + CNT_W'(tl);
        c_strobe  = c_drive + CNT_W'(1);
        c_ack_hi  = c_strobe + CNT_W'(hl);
        c_ack_end = c_ack_hi + CNT_W'(1);

        at_strobe = running && (cnt == c_strobe);
        dq_oe     = running && (cnt >= c_drive) && (cnt <= c_strobe);
        sadr_oe   = at_strobe;
        ce_n      = !at_strobe;
        ale_n     = !at_strobe;
        sadr      = at_strobe ? addr : '0;
        ack_oe    = running && (cnt >= c_drive) && (cnt <= c_ack_end);
        ack       = running && (cnt == c_ack_hi);
    end
endmodule

// File: rtl/sram_rd_seq.sv
module sram_rd_seq
    import srs_pkg::*;
#(
    parameter int unsigned DQ_W      = 68,
    parameter int unsigned ID_W      = 5,
    parameter int unsigned ADR_W     = 22,
    parameter int unsigned LOW_W     = 14,
    parameter int unsigned HI_W      = 3,
    parameter int unsigned OP_W      = 2,
    parameter logic [1:0]  RD_OP     = 2'b01,
    parameter int unsigned SPACE_LSB = 19,
    parameter int unsigned ID_LSB    = 21,
    parameter int unsigned TLSZ_W    = 2,
    parameter int unsigned HLAT_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [HI_W-1:0]   cmd_hi,
    input  logic [DQ_W-1:0]   dq_in,
    input  logic [ID_W-1:0]   dev_id,
    input  logic [TLSZ_W-1:0] cfg_pipe,
    input  logic [HLAT_W-1:0] cfg_hlat,
    output logic              dq_oe,
    output logic [ADR_W-1:0]  sadr,
    output logic              sadr_oe,
    output logic              ce_n,
    output logic              ale_n,
    output logic              ack,
    output logic              ack_oe,
    output logic              busy
);
    localparam int unsigned CNT_W =
        $clog2(DRIVE_START + 4 + (1 << TLSZ_W) + (1 << HLAT_W));

    logic              rd_hit;
    logic [ADR_W-1:0]  dec_addr;
    srs_state_e        st;
    logic [CNT_W-1:0]  cnt;
    logic [ADR_W-1:0]  addr_q;
    logic [TLSZ_W-1:0] tl;
    logic [HLAT_W-1:0] hl;

    srs_decode #(
        .DQ_W(DQ_W), .ID_W(ID_W), .ADR_W(ADR_W), .LOW_W(LOW_W), .HI_W(HI_W),
        .OP_W(OP_W), .RD_OP(RD_OP), .SPACE_LSB(SPACE_LSB), .ID_LSB(ID_LSB)
    ) u_dec (
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_hi(cmd_hi),
        .dq_in(dq_in), .dev_id(dev_id), .rd_hit(rd_hit), .addr(dec_addr)
    );

    srs_seq #(
        .ADR_W(ADR_W), .TLSZ_W(TLSZ_W), .HLAT_W(HLAT_W), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst(rst), .rd_hit(rd_hit), .addr_in(dec_addr),
        .cfg_pipe(cfg_pipe), .cfg_hlat(cfg_hlat),
        .st(st), .cnt(cnt), .addr(addr_q), .tl(tl), .hl(hl)
    );

    srs_drive #(
        .ADR_W(ADR_W), .TLSZ_W(TLSZ_W), .HLAT_W(HLAT_W), .CNT_W(CNT_W)
    ) u_drv (
        .running(st == ST_RUN), .cnt(cnt), .addr(addr_q), .tl(tl), .hl(hl),
        .dq_oe(dq_oe), .sadr(sadr), .sadr_oe(sadr_oe), .ce_n(ce_n),
        .ale_n(ale_n), .ack(ack), .ack_oe(ack_oe)
    );

    assign busy = (st != ST_IDLE) || rd_hit;

    // R5: acknowledge first appears driven LOW
    a_r5_ack_starts_low: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_oe) |-> !ack);
    // R5: an acknowledge HIGH is followed by a driven LOW
    a_r5_ack_high_then_low: assert property (@(posedge clk) disable iff (rst)
        (ack_oe && ack) |=> (ack_oe && !ack));
    // R5: after the closing LOW the acknowledge is released
    a_r5_ack_release: assert property (@(posedge clk) disable iff (rst)
        (ack_oe && !ack && $past(ack)) |=> !ack_oe);
    // R5: strobes last one cycle
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
        !ce_n |=> ce_n);
    // R5: the data bus is taken one cycle before the address appears
    a_r5_dq_before_sadr: assert property (@(posedge clk) disable iff (rst)
        $rose(sadr_oe) |-> $past(dq_oe));
    // R8: the acknowledge is never driven outside a busy access
    a_r8_busy_covers_ack: assert property (@(posedge clk) disable iff (rst)
        ack_oe |-> busy);
    // R10: a reset leaves every enable low on the next cycle
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> (!ack_oe && !dq_oe && !sadr_oe && ce_n && ale_n));
endmodule

// File: tb/sram_rd_seq_test.sv
module sram_rd_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] MY_ID = 5'h0B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [2:0]  cmd_hi = '0;
    logic [67:0] dq_in = '0;
    logic [4:0]  dev_id = MY_ID;
    logic [1:0]  cfg_pipe = '0;
    logic [2:0]  cfg_hlat = '0;
    logic        dq_oe, sadr_oe, ce_n, ale_n, ack, ack_oe, busy;
    logic [21:0] sadr;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_rd_seq uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_hi(cmd_hi), .dq_in(dq_in), .dev_id(dev_id), .cfg_pipe(cfg_pipe),
        .cfg_hlat(cfg_hlat), .dq_oe(dq_oe), .sadr(sadr), .sadr_oe(sadr_oe),
        .ce_n(ce_n), .ale_n(ale_n), .ack(ack), .ack_oe(ack_oe), .busy(busy)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R10";

    // behavioural reference: 0 idle, 1 waiting for 1B, >=2 cycle number
    int          m_cyc = 0;
    int          m_t = 0, m_h = 0;
    logic [21:0] m_addr = '0;

    function automatic bit instr_ok();
        return cmd_valid && cmd_op == 2'b01 && dq_in[20:19] == 2'b10 &&
               dq_in[25:21] == dev_id;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit e_dq, e_sa, e_ack, e_aoe, e_busy;
        logic [21:0] e_adr;
        int n = m_cyc;
        e_dq  = (n >= 2) && n >= 4 + m_t && n <= 5 + m_t;
        e_sa  = (n >= 2) && n == 5 + m_t;
        e_aoe = (n >= 2) && n >= 4 + m_t && n <= 6 + m_t + m_h;
        e_ack = (n >= 2) && n == 5 + m_t + m_h;
        e_busy = (n != 0) || (!rst && instr_ok());
        e_adr = e_sa ? m_addr : '0;
        chk({cur_req, "/R5"}, "dq_oe", dq_oe, e_dq);
        chk({cur_req, "/R5"}, "sadr_oe", sadr_oe, e_sa);
        chk({cur_req, "/R5"}, "ce_n", ce_n, !e_sa);
        chk({cur_req, "/R5"}, "ale_n", ale_n, !e_sa);
        chk({cur_req, "/R7"}, "ack", ack, e_ack);
        chk({cur_req, "/R7"}, "ack_oe", ack_oe, e_aoe);
        chk({cur_req, "/R4"}, "sadr", sadr, e_adr);
        chk({cur_req, "/R8"}, "busy", busy, e_busy);
    endtask

    task automatic advance();
        if (rst) begin
            m_cyc = 0;
        end else if (m_cyc == 0) begin
            if (instr_ok()) begin
                m_cyc  = 1;
                m_addr = {cmd_hi, 5'b0, dq_in[13:0]};
            end
        end else if (m_cyc == 1) begin
            if (instr_ok()) begin
                m_cyc = 2; m_t = cfg_pipe; m_h = cfg_hlat;
            end else m_cyc = 0;
        end else if (m_cyc == 6 + m_t + m_h) m_cyc = 0;
        else m_cyc++;
    endtask

    task automatic tick(bit v, logic [1:0] op, logic [2:0] hi, logic [1:0] sp,
                        logic [4:0] id, logic [13:0] ad);
        cmd_valid = v;
        cmd_op    = op;
        cmd_hi    = hi;
        dq_in     = '0;
        if (v) begin
            dq_in[13:0]  = ad;
            dq_in[20:19] = sp;
            dq_in[25:21] = id;
        end
        @(negedge clk);
        compare();
        @(posedge clk);
        #1;
        advance();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(0, 2'b00, 3'b0, 2'b00, 5'b0, 14'b0);
    endtask

    task automatic rd(logic [2:0] hi, logic [13:0] ad);
        tick(1, 2'b01, hi, 2'b10, MY_ID, ad);
        tick(1, 2'b01, hi, 2'b10, MY_ID, ad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        cur_req = "R10"; idle(3);
        rst = 1'b0;
        cur_req = "R5";  rd(3'd5, 14'h2ABC); idle(8);
        cur_req = "R2";
        tick(1, 2'b01, 3'd1, 2'b01, MY_ID, 14'h11); tick(1, 2'b01, 3'd1, 2'b01, MY_ID, 14'h11); idle(4);
        cur_req = "R3";
        tick(1, 2'b01, 3'd2, 2'b10, 5'h0C, 14'h22); tick(1, 2'b01, 3'd2, 2'b10, 5'h0C, 14'h22); idle(4);
        cur_req = "R1";
        tick(1, 2'b01, 3'd3, 2'b10, MY_ID, 14'h33); idle(6);
        tick(1, 2'b11, 3'd3, 2'b10, MY_ID, 14'h33); tick(1, 2'b11, 3'd3, 2'b10, MY_ID, 14'h33); idle(4);
        cur_req = "R6";  cfg_pipe = 2; rd(3'd7, 14'h3FFF); idle(12);
        cfg_pipe = 3; rd(3'd0, 14'h0001); idle(12);
        cur_req = "R7";  cfg_pipe = 0; cfg_hlat = 3; rd(3'd6, 14'h1234); idle(12);
        cfg_pipe = 3; cfg_hlat = 7; rd(3'd4, 14'h0F0F); idle(20);
        cfg_pipe = 1; cfg_hlat = 2; rd(3'd2, 14'h2222); idle(12);
        cur_req = "R9";  cfg_pipe = 0; cfg_hlat = 0; rd(3'd1, 14'h0ACE);
        cfg_pipe = 3; cfg_hlat = 5; idle(10);
        cfg_pipe = 0; cfg_hlat = 0;
        cur_req = "R8";  rd(3'd5, 14'h0505); idle(1); rd(3'd6, 14'h0606); idle(8);
        rd(3'd1, 14'h0101); idle(5); rd(3'd2, 14'h0202); idle(8);
        cur_req = "R10"; rd(3'd3, 14'h0303); idle(3);
        rst = 1'b1; idle(1); rst = 1'b0; idle(6);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule